// File: doc/BRIEF.md
# SMM Protected Memory Window Decoder

This block is a combinational address decoder that sits between memory requesters (processor cores and bus-master DMA engines) and system RAM. It guards a window at the top of low memory that is reserved for system management mode (SMM). Two configuration inputs control the window: an enable bit and a two-bit size selector. The window always ends at the top of low memory. Its base therefore moves down as the selected size grows.

Each request carries an address, a read/write flag, a byte-enable mask, an SMM flag and a requester type. The decoder answers in the same cycle. A request goes either to RAM, with its address unchanged, or to an internal sink. Software outside SMM and every DMA engine see the guarded window as a sink. Reads from the sink return all-ones on the enabled byte lanes, and writes to it are dropped. Processor accesses made in SMM pass through to RAM at the same address.

Top module: `smm_win_guard`

## Requirements
- R1: While `win_en_i` is 0, every valid request is routed to RAM, whatever the size selector, address, SMM flag or requester type.
- R2: The size selector `win_sel_i` encodes the window size as 2'b00 = 1 MB, 2'b01 = 2 MB and 2'b10 = 8 MB. The value 2'b11 gives a window of zero size, so nothing is intercepted even with the enable bit set.
- R3: The window covers addresses from `TOLM - size` up to `TOLM - 1` inclusive. Addresses below that base, and addresses at or above `TOLM`, always route to RAM.
- R4: A processor read (`req_dma_i`=0) made outside SMM that falls inside an active window goes to the sink. With all byte enables set, it returns 32'hFFFF_FFFF.
- R5: A DMA request (`req_dma_i`=1) that falls inside an active window goes to the sink even when `req_smm_i` is 1. DMA is never treated as SMM.
- R6: A processor request made in SMM that falls inside the window goes to RAM. `ram_addr_o` equals the request address, with no offset applied.
- R7: A write that goes to the sink is discarded. `route_ram_o` is 0 and `rsp_rdata_o` is 0.
- R8: On a sink read, byte lane i of `rsp_rdata_o` (bits 8i+7 down to 8i, in little-endian lane order) is 8'hFF when `req_be_i[i]` is 1 and 8'h00 when it is 0.
- R9: `req_ready_o` is always 1 and `rsp_valid_o` follows `req_valid_i` in the same cycle. A valid request asserts exactly one of `route_ram_o` and `route_sink_o`. An idle cycle asserts neither, and `ram_addr_o` and `rsp_rdata_o` are 0.
- R10: A change of `win_en_i` or `win_sel_i` takes effect on the very next request presented, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | DATA_W/8 | Byte-lane enables |
| req_smm_i | input | 1 | Requester is in system management mode |
| req_dma_i | input | 1 | 1 = bus-master DMA, 0 = processor |
| win_en_i | input | 1 | Protected window enable |
| win_sel_i | input | 2 | Window size selector |
| req_ready_o | output | 1 | Request accepted (always 1) |
| rsp_valid_o | output | 1 | Response valid, same cycle as request |
| route_ram_o | output | 1 | Request forwarded to RAM |
| route_sink_o | output | 1 | Request absorbed by the sink |
| ram_addr_o | output | ADDR_W | Address presented to RAM when routed there |
| rsp_rdata_o | output | DATA_W | Sink read data, zero otherwise |

## Verification
The embedded assertions check several properties on every evaluation. A valid request always has exactly one route and an idle cycle has none. A disabled window never sinks anything. A RAM route never carries sink data and always keeps the request address. Any live window base is aligned to 1 MB and lies within 8 MB below the top of low memory.

Some behaviour can only be shown by the bench's sweeps, which compare against values computed from the requirements. These cover the exact size picked by each selector code and the inclusive and exclusive edges of the window. They also cover the SMM and DMA pass/sink matrix, the per-lane all-ones pattern for every byte-enable mask, and the immediate effect of a configuration change.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;

   localparam int unsigned SEL_W    = 2;
   localparam int unsigned MB_SHIFT = 20;
   localparam int unsigned MB_W     = 4;

   typedef enum logic [SEL_W-1:0] {
      SZ_1M   = 2'b00,
      SZ_2M   = 2'b01,
      SZ_8M   = 2'b10,
      SZ_NONE = 2'b11
   } win_sel_e;

   typedef struct packed {
      logic ram;
      logic sink;
   } route_t;

   // Size in megabytes for a selector code; zero for the reserved code.
   function automatic logic [MB_W-1:0] sel_to_mb(input win_sel_e s);
      logic [MB_W-1:0] mb;
      unique case (s)
         SZ_1M:   mb = 4'd1;
         SZ_2M:   mb = 4'd2;
         SZ_8M:   mb = 4'd8;
         default: mb = 4'd0;
      endcase
      return mb;
   endfunction

endpackage

// File: rtl/smm_win_geom.sv
module smm_win_geom
   import smm_win_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h1000_0000
) (
   input  logic                 en_i,
   input  logic [SEL_W-1:0]     sel_i,
   output logic                 live_o,
   output logic [ADDR_W-1:0]    base_o
);

   localparam logic [ADDR_W-1:0] MB_ONE  = ADDR_W'(1) << MB_SHIFT;
   localparam logic [ADDR_W-1:0] MAX_WIN = ADDR_W'(8) << MB_SHIFT;

   generate
      if (ADDR_W < MB_SHIFT + MB_W) begin : g_bad_width
         $error("smm_win_geom: ADDR_W too small for an 8 MB window");
      end
      if ((TOLM % MB_ONE) != '0) begin : g_bad_align
         $error("smm_win_geom: TOLM must be 1 MB aligned");
      end
      if (TOLM < MAX_WIN) begin : g_bad_tolm
         $error("smm_win_geom: TOLM must be at least 8 MB");
      end
   endgenerate

   logic [MB_W-1:0]   mb;
   logic [ADDR_W-1:0] size;

   always_comb begin
      mb     = en_i ? sel_to_mb(win_sel_e'(sel_i)) : '0;
      size   = {{(ADDR_W-MB_W){1'b0}}, mb} << MB_SHIFT;
      live_o = (size != '0);
      base_o = TOLM - size;
   end

   always_comb begin
      if (live_o) begin
         assert_base_aligned_R3: assert (base_o[MB_SHIFT-1:0] == '0)
            else $error("window base not 1 MB aligned");
         assert_base_range_R3: assert ((base_o < TOLM) && (base_o >= TOLM - MAX_WIN))
            else $error("window base outside the 8 MB span below TOLM");
      end
      if (!en_i) begin
         assert_disabled_dead_R1: assert (!live_o)
            else $error("window live while disabled");
      end
   end

endmodule

// File: rtl/smm_win_decode.sv
module smm_win_decode
   import smm_win_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h1000_0000
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              smm_i,
   input  logic              dma_i,
   input  logic              live_i,
   input  logic [ADDR_W-1:0] base_i,
   output route_t            route_o
);

   logic in_win;
   logic trusted;

   always_comb begin
      in_win       = live_i && (addr_i >= base_i) && (addr_i < TOLM);
      trusted      = smm_i && !dma_i;
      route_o.sink = valid_i && in_win && !trusted;
      route_o.ram  = valid_i && !route_o.sink;
   end

   always_comb begin
      if (valid_i) begin
         assert_one_route_R9: assert ($countones({route_o.ram, route_o.sink}) == 1)
            else $error("valid request without exactly one route");
      end else begin
         assert_idle_route_R9: assert ({route_o.ram, route_o.sink} == 2'b00)
            else $error("route asserted while idle");
      end
      if (!live_i) begin
         assert_no_sink_dead_R1: assert (!route_o.sink)
            else $error("sink selected with no live window");
      end
      if (addr_i >= TOLM) begin
         assert_above_tolm_ram_R3: assert (!route_o.sink)
            else $error("address above TOLM sunk");
      end
   end

endmodule

// File: rtl/smm_win_sink.sv
module smm_win_sink #(
   parameter int unsigned DATA_W = 32,
   parameter logic [7:0]  FILL   = 8'hFF
) (
   input  logic                  sel_i,
   input  logic                  write_i,
   input  logic [DATA_W/8-1:0]   be_i,
   output logic [DATA_W-1:0]     rdata_o
);

   localparam int unsigned BE_W = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_data
         $error("smm_win_sink: DATA_W must be a nonzero multiple of 8");
      end
   endgenerate

   logic rd_hit;
   assign rd_hit = sel_i && !write_i;

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      assign rdata_o[8*i +: 8] = (rd_hit && be_i[i]) ? FILL : 8'h00;
   end

endmodule

// File: rtl/smm_win_guard.sv
module smm_win_guard
   import smm_win_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h1000_0000
) (
   input  logic                  req_valid_i,
   input  logic [ADDR_W-1:0]     req_addr_i,
   input  logic                  req_write_i,
   input  logic [DATA_W/8-1:0]   req_be_i,
   input  logic                  req_smm_i,
   input  logic                  req_dma_i,
   input  logic                  win_en_i,
   input  logic [1:0]            win_sel_i,
   output logic                  req_ready_o,
   output logic                  rsp_valid_o,
   output logic                  route_ram_o,
   output logic                  route_sink_o,
   output logic [ADDR_W-1:0]     ram_addr_o,
   output logic [DATA_W-1:0]     rsp_rdata_o
);

   logic              live;
   logic [ADDR_W-1:0] base;
   route_t            route;

   smm_win_geom #(.ADDR_W(ADDR_W), .TOLM(TOLM)) u_geom (
      .en_i   (win_en_i),
      .sel_i  (win_sel_i),
      .live_o (live),
      .base_o (base)
   );

   smm_win_decode #(.ADDR_W(ADDR_W), .TOLM(TOLM)) u_dec (
      .valid_i (req_valid_i),
      .addr_i  (req_addr_i),
      .smm_i   (req_smm_i),
      .dma_i   (req_dma_i),
      .live_i  (live),
      .base_i  (base),
      .route_o (route)
   );

   smm_win_sink #(.DATA_W(DATA_W)) u_sink (
      .sel_i   (route.sink),
      .write_i (req_write_i),
      .be_i    (req_be_i),
      .rdata_o (rsp_rdata_o)
   );

   assign req_ready_o  = 1'b1;
   assign rsp_valid_o  = req_valid_i;
   assign route_ram_o  = route.ram;
   assign route_sink_o = route.sink;
   assign ram_addr_o   = route.ram ? req_addr_i : '0;

   always_comb begin
      if (route_ram_o) begin
         assert_ram_no_data_R7: assert (rsp_rdata_o == '0)
            else $error("sink data on a RAM route");
         assert_ram_same_addr_R6: assert (ram_addr_o == req_addr_i)
            else $error("RAM address translated");
      end
      if (route_sink_o && req_write_i) begin
         assert_write_dropped_R7: assert (!route_ram_o && rsp_rdata_o == '0)
            else $error("sink write not discarded");
      end
      if (route_sink_o && req_smm_i && !req_dma_i) begin
         assert_smm_cpu_pass_R6: assert (1'b0)
            else $error("SMM processor access sunk");
      end
   end

endmodule

// File: tb/sim_smm_win_guard.sv
module sim_smm_win_guard;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned DATA_W = 32;
   localparam logic [31:0] TOLM = 32'h1000_0000;
   localparam logic [31:0] MB   = 32'h0010_0000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              req_valid = 1'b0;
   logic [31:0]       req_addr  = '0;
   logic              req_write = 1'b0;
   logic [3:0]        req_be    = 4'hF;
   logic              req_smm   = 1'b0;
   logic              req_dma   = 1'b0;
   logic              win_en    = 1'b0;
   logic [1:0]        win_sel   = 2'b00;
   logic              req_ready, rsp_valid, route_ram, route_sink;
   logic [31:0]       ram_addr, rsp_rdata;

   int total = 0;
   int bad   = 0;

   smm_win_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOLM(TOLM)) u0 (
      .req_valid_i (req_valid), .req_addr_i (req_addr), .req_write_i (req_write),
      .req_be_i (req_be), .req_smm_i (req_smm), .req_dma_i (req_dma),
      .win_en_i (win_en), .win_sel_i (win_sel),
      .req_ready_o (req_ready), .rsp_valid_o (rsp_valid),
      .route_ram_o (route_ram), .route_sink_o (route_sink),
      .ram_addr_o (ram_addr), .rsp_rdata_o (rsp_rdata)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_size(input logic en, input logic [1:0] sel);
      if (!en) return 32'd0;
      case (sel)
         2'd0: return MB;
         2'd1: return 2 * MB;
         2'd2: return 8 * MB;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] pick_addr(input int p, input logic [31:0] base);
      case (p)
         0: return 32'h0;
         1: return TOLM - 9 * MB;
         2: return base - 1;
         3: return base;
         4: return base + 4;
         5: return TOLM - 4;
         6: return TOLM - 1;
         7: return TOLM;
         8: return TOLM + 4;
         default: return 32'hFFFF_FFFC;
      endcase
   endfunction

   task automatic step;
      @(negedge clk);
   endtask

   task automatic settle;
      #(CLK_PERIOD/4);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // idle state (R9)
      step(); settle();
      check("R9 idle ready", {31'd0, req_ready}, 32'd1);
      check("R9 idle valid", {31'd0, rsp_valid}, 32'd0);
      check("R9 idle routes", {30'd0, route_ram, route_sink}, 32'd0);
      check("R9 idle rdata", rsp_rdata, 32'd0);
      check("R9 idle addr", ram_addr, 32'd0);

      // full sweep: R1..R7
      for (int en = 0; en < 2; en++) begin
         for (int sel = 0; sel < 4; sel++) begin
            for (int p = 0; p < 10; p++) begin
               for (int m = 0; m < 8; m++) begin
                  logic [31:0] sz, base, a, e_rd;
                  logic hit, e_sink;
                  string tag;
                  sz   = exp_size(en[0], sel[1:0]);
                  base = TOLM - sz;
                  a    = pick_addr(p, base);
                  hit  = (sz != 0) && (a >= base) && (a < TOLM);
                  e_sink = hit && (m[1] || !m[0]);
                  e_rd = (e_sink && !m[2]) ? 32'hFFFF_FFFF : 32'h0;
                  if (!en[0])           tag = "R1";
                  else if (sel == 3)    tag = "R2";
                  else if (!hit)        tag = "R3";
                  else if (m[1])        tag = "R5";
                  else if (m[0])        tag = "R6";
                  else if (m[2])        tag = "R7";
                  else                  tag = "R4";
                  step();
                  win_en = en[0]; win_sel = sel[1:0];
                  req_valid = 1'b1; req_addr = a; req_be = 4'hF;
                  req_smm = m[0]; req_dma = m[1]; req_write = m[2];
                  settle();
                  check(tag, {30'd0, route_ram, route_sink}, {30'd0, !e_sink, e_sink});
                  check(tag, rsp_rdata, e_rd);
                  check(tag, ram_addr, e_sink ? 32'h0 : a);
                  check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
               end
            end
         end
      end

      // byte-lane sweep on sink reads (R8)
      for (int b = 0; b < 16; b++) begin
         logic [31:0] e;
         for (int i = 0; i < 4; i++) e[8*i +: 8] = b[i] ? 8'hFF : 8'h00;
         step();
         win_en = 1'b1; win_sel = 2'b10;
         req_valid = 1'b1; req_addr = TOLM - 8 * MB; req_write = 1'b0;
         req_smm = 1'b0; req_dma = 1'b0; req_be = b[3:0];
         settle();
         check("R8 lane data", rsp_rdata, e);
         check("R8 sink route", {31'd0, route_sink}, 32'd1);
      end

      // configuration change takes effect at once (R10)
      step();
      win_en = 1'b1; win_sel = 2'b00; req_be = 4'hF;
      req_valid = 1'b1; req_addr = TOLM - 2 * MB; req_write = 1'b0;
      req_smm = 1'b0; req_dma = 1'b0;
      settle();
      check("R10 1MB misses", {31'd0, route_sink}, 32'd0);
      step(); win_sel = 2'b01; settle();
      check("R10 2MB hits", {31'd0, route_sink}, 32'd1);
      step(); win_sel = 2'b11; settle();
      check("R10 reserved code", {31'd0, route_sink}, 32'd0);
      step(); win_sel = 2'b01; win_en = 1'b0; settle();
      check("R10 disable", {31'd0, route_ram}, 32'd1);

      // back to idle (R9)
      step(); req_valid = 1'b0; settle();
      check("R9 idle again", {30'd0, route_ram, route_sink}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule